// File: doc/BRIEF.md
# Dual-Bank Flash Controller Front-End

This block models the register-level front end of an on-chip flash controller with two banks. Software reaches it through one request channel. A request either addresses the controller's registers or reads the flash array directly. The array is organised as two banks of pages. A page can be erased to all ones. Up to a buffer's worth of adjacent words can be programmed in one operation, and programming can only clear bits.

An operation is launched in two steps. First the arming key is written to the key register. Then a recognised opcode is written to the control register of one bank. That bank then stays busy for a parameterised number of clock cycles. While it is busy, its control register reads back the running opcode, and any direct array read of that bank is held off through back-pressure. The other bank and the register space stay reachable. Errors gather in a sticky status register, which is cleared by reading it.

The geometry is set by parameters. The defaults are 4 pages of 32 words per bank, a 32-word buffer and a 6-cycle latency, which keeps the model small. The full-size part uses 128 pages of 512 words per bank, and the structure is the same at that size.

Top module: `dual_bank_flash_fe`

## Requirements
- R1: After reset every array word reads 0xFFFFFFFF, both control registers read 0, and the error register reads 0.
- R2: Array reads take `req_size` 0 for a byte, 1 for a halfword and 2 for a word. The result is zero-extended in the low bits of `rsp_rdata`. A byte comes from lane `req_addr[1:0]`. A halfword comes from lane `req_addr[1]`.
- R3: A write to the array space is accepted and has no effect on the stored data.
- R4: Register word index 41 is the key and 42/43 are the bank 0/1 control registers. Index 40 holds the word offset in bits [OFF_W-1:0] and the word count minus one in bits [20:16]. Indices 0..31 are the buffer. Writing 0xB11924E1 to the key and then 0x27182818 to a control register programs count words starting at the offset. Each stored word becomes old AND buffer[i].
- R5: After arming, writing 0x31415927 to a control register sets every word of the page that contains the offset to 0xFFFFFFFF.
- R6: A recognised opcode is ignored unless the key register last received 0xB11924E1. Any control write disarms the block, and so does any other value written to the key.
- R7: A control write of any value other than the two opcodes sets error bit 0.
- R8: An armed program with offset+count beyond the bank, or an armed erase with an offset outside the bank, sets error bit 1 and changes nothing.
- R9: An armed, recognised control write to a bank that is already busy sets error bit 2 and starts nothing.
- R10: After a launch, that bank's control register reads the opcode for exactly OP_LAT cycles and then reads 0.
- R11: `req_ready` is low only when an array read targets a busy bank. Register accesses and reads of the idle bank are accepted at once.
- R12: Reading the error register (index 44) returns the accumulated bits, and the register then reads 0.
- R13: Every accepted read produces `rsp_valid` for exactly one cycle, in the cycle after acceptance. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_reg | input | 1 | 1 = register space, 0 = flash array |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Array read width: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address; register index in [7:2] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle, cannot be stalled |
| rsp_rdata | output | 32 | Read data |

## Verification
A wrong busy counter shows first in `req_ready`. A bank read is then either stalled one cycle too long or let through early, and this is visible in the first cycle after the launch where the two differ. It also shows in the control register, which reads nonzero in the wrong cycle. A corrupted array word, a wrong buffer index or a wrong page decode only appears when that word is read back. This is why every programmed and erased location is read soon after the operation completes. A stuck arming flag or error bit shows on the next ignored launch, or on the read of the error register after it.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int N_BANKS = 2;
  localparam logic [31:0] KEY_ARM   = 32'hB11924E1;
  localparam logic [31:0] OPC_PROG  = 32'h27182818;
  localparam logic [31:0] OPC_ERASE = 32'h31415927;

  localparam logic [5:0] IDX_TRANS = 6'd40;
  localparam logic [5:0] IDX_KEY   = 6'd41;
  localparam logic [5:0] IDX_CTL0  = 6'd42;
  localparam logic [5:0] IDX_CTL1  = 6'd43;
  localparam logic [5:0] IDX_ERR   = 6'd44;

  localparam int ERR_W     = 3;
  localparam int ERR_OPC   = 0;
  localparam int ERR_RANGE = 1;
  localparam int ERR_BUSY  = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/fc_bank_timer.sv
module fc_bank_timer #(
  parameter int OP_LAT = 6,
  localparam int CW = $clog2(OP_LAT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] opcode_in,
  output logic        busy,
  output logic [31:0] op_out
);
  logic [CW-1:0] cnt_q;
  logic [31:0]   op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      op_q  <= '0;
    end else if (start) begin
      cnt_q <= CW'(OP_LAT);
      op_q  <= opcode_in;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = (cnt_q != '0);
  assign op_out = busy ? op_q : 32'h0;
endmodule

// File: rtl/fc_regs.sv
module fc_regs
  import fc_pkg::*;
#(
  parameter int BUF_WORDS  = 32,
  parameter int BANK_WORDS = 128,
  localparam int OFF_W = $clog2(BANK_WORDS),
  localparam int SZ_W  = $clog2(BUF_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [5:0]                    idx,
  input  logic [31:0]                   wdata,
  input  logic [N_BANKS-1:0]            busy,
  input  logic [31:0]                   op0,
  input  logic [31:0]                   op1,
  output logic [N_BANKS-1:0]            start,
  output logic                          start_erase,
  output logic [OFF_W-1:0]              tr_off,
  output logic [SZ_W-1:0]               tr_size,
  output logic [BUF_WORDS-1:0][31:0]    buf_q,
  output logic [31:0]                   reg_rdata,
  output logic                          armed,
  output logic [ERR_W-1:0]              err_q
);
  logic ctl_wr, ctl_bank, is_prog, is_erase, known, range_bad, bank_busy, go;
  logic [ERR_W-1:0] err_set;

  always_comb begin
    ctl_wr    = wr_en && (idx == IDX_CTL0 || idx == IDX_CTL1);
    ctl_bank  = (idx == IDX_CTL1);
    is_prog   = (wdata == OPC_PROG);
    is_erase  = (wdata == OPC_ERASE);
    known     = is_prog || is_erase;
    bank_busy = busy[ctl_bank];
    if (is_prog) range_bad = (int'(tr_off) + int'(tr_size) + 1) > BANK_WORDS;
    else         range_bad = int'(tr_off) >= BANK_WORDS;
    go = ctl_wr && known && armed && !bank_busy && !range_bad;
    err_set = '0;
    err_set[ERR_OPC]   = ctl_wr && !known;
    err_set[ERR_BUSY]  = ctl_wr && known && armed && bank_busy;
    err_set[ERR_RANGE] = ctl_wr && known && armed && !bank_busy && range_bad;
    start       = '0;
    start[ctl_bank] = go;
    start_erase = is_erase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      tr_off  <= '0;
      tr_size <= '0;
      buf_q   <= '0;
      err_q   <= '0;
    end else begin
      if (wr_en && idx == IDX_KEY) armed <= (wdata == KEY_ARM);
      else if (ctl_wr)             armed <= 1'b0;
      if (wr_en && idx == IDX_TRANS) begin
        tr_off  <= wdata[OFF_W-1:0];
        tr_size <= wdata[16 +: SZ_W];
      end
      if (wr_en && int'(idx) < BUF_WORDS) buf_q[idx[SZ_W-1:0]] <= wdata;
      err_q <= ((rd_en && idx == IDX_ERR) ? '0 : err_q) | err_set;
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (int'(idx) < BUF_WORDS) reg_rdata = buf_q[idx[SZ_W-1:0]];
    else begin
      case (idx)
        IDX_TRANS: reg_rdata = 32'(tr_off) | (32'(tr_size) << 16);
        IDX_CTL0:  reg_rdata = op0;
        IDX_CTL1:  reg_rdata = op1;
        IDX_ERR:   reg_rdata = 32'(err_q);
        default:   reg_rdata = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/fc_array.sv
module fc_array
  import fc_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_WORDS = 32,
  parameter int BUF_WORDS  = 32,
  localparam int BANK_WORDS = PAGES * PAGE_WORDS,
  localparam int OFF_W = $clog2(BANK_WORDS),
  localparam int SZ_W  = $clog2(BUF_WORDS),
  localparam int TOT_WORDS = N_BANKS * BANK_WORDS,
  localparam int WA_W  = $clog2(TOT_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_BANKS-1:0]         start,
  input  logic                       erase,
  input  logic [OFF_W-1:0]           off,
  input  logic [SZ_W-1:0]            size,
  input  logic [BUF_WORDS-1:0][31:0] buf_d,
  input  logic [WA_W-1:0]            rd_addr,
  output logic [31:0]                rd_word
);
  logic [31:0]      mem_w [TOT_WORDS];
  logic [OFF_W-1:0] off_page;

  assign off_page = off / OFF_W'(PAGE_WORDS);

  for (genvar j = 0; j < TOT_WORDS; j++) begin : g_word
    localparam int B  = j / BANK_WORDS;
    localparam int LW = j % BANK_WORDS;
    localparam int PG = LW / PAGE_WORDS;
    logic [OFF_W-1:0] rel;
    logic             hit_prog, hit_erase;
    logic [31:0]      word_q;

    assign rel       = OFF_W'(LW) - off;
    assign hit_erase = start[B] && erase && (off_page == OFF_W'(PG));
    assign hit_prog  = start[B] && !erase && (LW >= int'(off)) &&
                       (int'(rel) <= int'(size));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '1;
      else if (hit_erase) word_q <= '1;
      else if (hit_prog)  word_q <= word_q & buf_d[rel[SZ_W-1:0]];
    end
    assign mem_w[j] = word_q;
  end

  assign rd_word = mem_w[rd_addr];
endmodule

// File: rtl/dual_bank_flash_fe.sv
module dual_bank_flash_fe
  import fc_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_WORDS = 32,
  parameter int BUF_WORDS  = 32,
  parameter int OP_LAT     = 6,
  localparam int BANK_WORDS = PAGES * PAGE_WORDS,
  localparam int OFF_W  = $clog2(BANK_WORDS),
  localparam int SZ_W   = $clog2(BUF_WORDS),
  localparam int WA_W   = OFF_W + 1,
  localparam int ADDR_W = (WA_W + 2 > 8) ? WA_W + 2 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_reg,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  logic [N_BANKS-1:0]         bank_busy, bank_start;
  logic [31:0]                bank_op [N_BANKS];
  logic                       start_erase, armed, rd_bank, acc, reg_wr, reg_rd;
  logic [5:0]                 reg_idx;
  logic [OFF_W-1:0]           tr_off;
  logic [SZ_W-1:0]            tr_size;
  logic [BUF_WORDS-1:0][31:0] buf_q;
  logic [31:0]                reg_rdata, arr_word, arr_fmt;
  logic [ERR_W-1:0]           err_q;

  assign rd_bank   = req_addr[OFF_W+2];
  assign req_ready = !(req_valid && !req_reg && !req_write && bank_busy[rd_bank]);
  assign acc       = req_valid && req_ready;
  assign reg_wr    = acc && req_reg && req_write;
  assign reg_rd    = acc && req_reg && !req_write;
  assign reg_idx   = req_addr[7:2];

  fc_regs #(.BUF_WORDS(BUF_WORDS), .BANK_WORDS(BANK_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .idx(reg_idx),
    .wdata(req_wdata), .busy(bank_busy), .op0(bank_op[0]), .op1(bank_op[1]),
    .start(bank_start), .start_erase(start_erase), .tr_off(tr_off),
    .tr_size(tr_size), .buf_q(buf_q), .reg_rdata(reg_rdata), .armed(armed),
    .err_q(err_q)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    fc_bank_timer #(.OP_LAT(OP_LAT)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(bank_start[b]),
      .opcode_in(start_erase ? OPC_ERASE : OPC_PROG),
      .busy(bank_busy[b]), .op_out(bank_op[b])
    );
  end

  fc_array #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .BUF_WORDS(BUF_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .start(bank_start), .erase(start_erase),
    .off(tr_off), .size(tr_size), .buf_d(buf_q),
    .rd_addr(req_addr[WA_W+1:2]), .rd_word(arr_word)
  );

  always_comb begin
    case (acc_size_e'(req_size))
      SZ_BYTE: arr_fmt = 32'((arr_word >> (8 * req_addr[1:0])) & 32'hFF);
      SZ_HALF: arr_fmt = 32'((arr_word >> (16 * req_addr[1])) & 32'hFFFF);
      default: arr_fmt = arr_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !req_write;
      if (acc && !req_write) rsp_rdata <= req_reg ? reg_rdata : arr_fmt;
    end
  end
endmodule

// File: rtl/fc_chk.sv
module fc_chk
  import fc_pkg::*;
#(
  parameter int OP_LAT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_reg,
  input logic               req_write,
  input logic               rd_bank,
  input logic [1:0]         busy,
  input logic               armed,
  input logic [ERR_W-1:0]   err_q,
  input logic               reg_rd,
  input logic [5:0]         reg_idx,
  input logic               rsp_valid
);
  int run0, run1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run0 <= 0;
      run1 <= 0;
    end else begin
      run0 <= busy[0] ? run0 + 1 : 0;
      run1 <= busy[1] ? run1 + 1 : 0;
    end
  end

  // R11
  stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_reg && !req_write) |-> !busy[rd_bank]);

  // R13
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R6
  key_gate0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> $past(armed));

  // R6
  key_gate1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[1]) |-> $past(armed));

  // R10
  busy_len0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> (run0 == OP_LAT));

  // R10
  busy_len1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[1]) |-> (run1 == OP_LAT));

  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == IDX_ERR) |=> (err_q == '0));
endmodule

bind dual_bank_flash_fe fc_chk #(.OP_LAT(OP_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_reg(req_reg), .req_write(req_write), .rd_bank(rd_bank), .busy(bank_busy),
  .armed(armed), .err_q(err_q), .reg_rd(reg_rd), .reg_idx(reg_idx),
  .rsp_valid(rsp_valid)
);

// File: tb/test_dual_bank_flash_fe.sv
`timescale 1ns/1ps
module test_dual_bank_flash_fe;
  localparam int PAGES = 4, PW = 32, BUFW = 32, LAT = 6;
  localparam int BW = PAGES * PW;
  localparam int OFF_W = $clog2(BW);
  localparam int ADDR_W = (OFF_W + 3 > 8) ? OFF_W + 3 : 8;
  localparam int unsigned KEY = 32'hB11924E1, PROG = 32'h27182818, ERASE = 32'h31415927;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_reg = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;

  dual_bank_flash_fe #(.PAGES(PAGES), .PAGE_WORDS(PW), .BUF_WORDS(BUFW), .OP_LAT(LAT)) i_dual_bank_flash_fe (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reg(req_reg), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int unsigned mm [2*BW];
  int unsigned mb [BUFW];
  int m_off, m_sz, m_err, bk, idx_m, base;
  int m_cnt [2];
  int unsigned m_op [2];
  bit m_armed, m_rv, acc_m;
  int unsigned m_rd;
  int st;

  function automatic bit m_ready();
    return !(req_valid && !req_reg && !req_write && m_cnt[req_addr[OFF_W+2]] != 0);
  endfunction

  function automatic int unsigned fmt(int unsigned w, int sz, int lo);
    if (sz == 0) return (w >> (8 * lo)) & 32'hFF;
    if (sz == 1) return (w >> (16 * (lo >> 1))) & 32'hFFFF;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 32'hFFFFFFFF;
      foreach (mb[i]) mb[i] = 0;
      m_off = 0; m_sz = 0; m_err = 0; m_armed = 0; m_rv = 0; m_rd = 0;
      m_cnt[0] = 0; m_cnt[1] = 0; m_op[0] = 0; m_op[1] = 0;
    end else begin
      acc_m = req_valid && m_ready();
      m_rv = acc_m && !req_write;
      st = -1;
      if (acc_m && req_reg) begin
        idx_m = int'(req_addr[7:2]);
        if (req_write) begin
          if (idx_m < BUFW) mb[idx_m] = req_wdata;
          else if (idx_m == 40) begin
            m_off = req_wdata & ((1 << OFF_W) - 1);
            m_sz = (req_wdata >> 16) & (BUFW - 1);
          end else if (idx_m == 41) m_armed = (req_wdata == KEY);
          else if (idx_m == 42 || idx_m == 43) begin
            bk = idx_m - 42;
            if (req_wdata != PROG && req_wdata != ERASE) m_err = m_err | 1;
            else if (m_armed) begin
              if (m_cnt[bk] != 0) m_err = m_err | 4;
              else if ((req_wdata == PROG && m_off + m_sz + 1 > BW) ||
                       (req_wdata == ERASE && m_off >= BW)) m_err = m_err | 2;
              else begin
                if (req_wdata == PROG)
                  for (int i = 0; i <= m_sz; i++) mm[bk*BW + m_off + i] &= mb[i];
                else begin
                  base = m_off - (m_off % PW);
                  for (int w = 0; w < PW; w++) mm[bk*BW + base + w] = 32'hFFFFFFFF;
                end
                st = bk;
                m_op[bk] = req_wdata;
              end
            end
            m_armed = 0;
          end
        end else begin
          if (idx_m < BUFW) m_rd = mb[idx_m];
          else if (idx_m == 40) m_rd = (m_sz << 16) | m_off;
          else if (idx_m == 42) m_rd = (m_cnt[0] != 0) ? m_op[0] : 0;
          else if (idx_m == 43) m_rd = (m_cnt[1] != 0) ? m_op[1] : 0;
          else if (idx_m == 44) begin m_rd = m_err; m_err = 0; end
          else m_rd = 0;
        end
      end else if (acc_m && !req_write) begin
        m_rd = fmt(mm[int'(req_addr[ADDR_W-1:2])], int'(req_size), int'(req_addr[1:0]));
      end
      for (int b = 0; b < 2; b++) begin
        if (st == b) m_cnt[b] = LAT;
        else if (m_cnt[b] > 0) m_cnt[b]--;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (req_ready !== m_ready()) begin
        failures++;
        $display("FAIL R11 ready act=%0b exp=%0b t=%0t", req_ready, m_ready(), $time);
      end
      checks++;
      if (rsp_valid !== m_rv || (m_rv && rsp_rdata !== m_rd)) begin
        failures++;
        $display("FAIL R13 rsp act=%0b/%h exp=%0b/%h t=%0t", rsp_valid, rsp_rdata, m_rv, m_rd, $time);
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    report();
    $finish;
  end

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(bit rg, bit wr, int sz, int addr, int unsigned wd,
                      output int unsigned rd, output int stalls);
    req_valid = 1; req_reg = rg; req_write = wr; req_size = 2'(sz);
    req_addr = ADDR_W'(addr); req_wdata = wd; stalls = 0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      stalls++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 0;
    rd = rsp_rdata;
  endtask

  task automatic wreg(int idx, int unsigned v);
    int unsigned d; int s;
    xfer(1, 1, 2, idx * 4, v, d, s);
  endtask

  task automatic rreg(int idx, output int unsigned v);
    int s;
    xfer(1, 0, 2, idx * 4, 0, v, s);
  endtask

  task automatic rarr(int bank, int word, int sz, int lo, output int unsigned v, output int s);
    xfer(0, 0, sz, (bank * BW + word) * 4 + lo, 0, v, s);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int unsigned v;
  int s;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1);
    // R1 reset state
    rarr(0, 0, 2, 0, v, s);  chk("R1 array erased", v, 32'hFFFFFFFF);
    rarr(1, BW-1, 2, 0, v, s); chk("R1 last word erased", v, 32'hFFFFFFFF);
    rreg(42, v); chk("R1 ctl0 idle", v, 0);
    rreg(44, v); chk("R1 error clear", v, 0);
    // R3 direct write ignored
    xfer(0, 1, 2, 0, 32'h0, v, s);
    rarr(0, 0, 2, 0, v, s); chk("R3 direct write ignored", v, 32'hFFFFFFFF);
    // R4 program four words into bank 1 at word 4
    wreg(0, 32'h12345678); wreg(1, 32'hA5A5A5A5);
    wreg(2, 32'h0F0F0F0F); wreg(3, 32'hFFFF0000);
    wreg(40, (3 << 16) | 4);
    wreg(41, KEY);
    wreg(43, PROG);
    rreg(43, v); chk("R10 ctl1 busy reads opcode", v, PROG);
    rarr(0, 0, 2, 0, v, s); chk("R11 idle bank not stalled", s, 0);
    rarr(1, 4, 2, 0, v, s);
    chk("R11 busy bank stall cycles", s, LAT - 2);
    chk("R4 programmed word0", v, 32'h12345678);
    rarr(1, 5, 2, 0, v, s); chk("R4 programmed word1", v, 32'hA5A5A5A5);
    rarr(1, 7, 2, 0, v, s); chk("R4 programmed word3", v, 32'hFFFF0000);
    rarr(1, 8, 2, 0, v, s); chk("R4 word past count untouched", v, 32'hFFFFFFFF);
    // R4 second program ANDs
    wreg(0, 32'hFF00FF00); wreg(40, 4); wreg(41, KEY); wreg(43, PROG);
    idle(LAT - 1);
    rreg(43, v); chk("R10 last busy cycle", v, PROG);
    rreg(43, v); chk("R10 control back to zero", v, 0);
    rarr(1, 4, 2, 0, v, s); chk("R4 AND of old and new", v, 32'h12005600);
    // R2 narrow reads
    rarr(1, 4, 0, 1, v, s); chk("R2 byte lane 1", v, 32'h56);
    rarr(1, 4, 0, 3, v, s); chk("R2 byte lane 3", v, 32'h12);
    rarr(1, 4, 1, 2, v, s); chk("R2 upper halfword", v, 32'h1200);
    // R5 erase page containing word 5 of bank 1
    wreg(40, 5); wreg(41, KEY); wreg(43, ERASE);
    idle(LAT + 1);
    rarr(1, 4, 2, 0, v, s); chk("R5 erased word4", v, 32'hFFFFFFFF);
    rarr(1, 6, 2, 0, v, s); chk("R5 erased word6", v, 32'hFFFFFFFF);
    // R6 launches without a valid key are ignored
    wreg(0, 32'h0); wreg(40, 0);
    wreg(42, PROG);
    rreg(42, v); chk("R6 no key, ctl0 idle", v, 0);
    rarr(0, 0, 2, 0, v, s); chk("R6 no key, data unchanged", v, 32'hFFFFFFFF);
    wreg(41, 32'h1); wreg(42, PROG);
    rarr(0, 0, 2, 0, v, s); chk("R6 wrong key, data unchanged", v, 32'hFFFFFFFF);
    wreg(41, KEY); wreg(42, 32'h0BADC0DE); wreg(42, PROG);
    rarr(0, 0, 2, 0, v, s); chk("R6 key consumed by control write", v, 32'hFFFFFFFF);
    // R7 / R12 unknown opcode
    rreg(44, v); chk("R7 unknown opcode error bit0", v, 1);
    rreg(44, v); chk("R12 error clears after read", v, 0);
    // R8 range overflow
    wreg(40, (3 << 16) | (BW - 2)); wreg(41, KEY); wreg(42, PROG);
    rreg(42, v); chk("R8 no launch on overflow", v, 0);
    rreg(44, v); chk("R8 range error bit1", v, 2);
    rarr(0, BW-2, 2, 0, v, s); chk("R8 data unchanged", v, 32'hFFFFFFFF);
    // R9 launch on busy bank
    wreg(40, 0); wreg(41, KEY); wreg(42, ERASE);
    wreg(41, KEY); wreg(42, PROG);
    rreg(44, v); chk("R9 busy error bit2", v, 4);
    idle(LAT + 1);
    rarr(0, 0, 2, 0, v, s); chk("R9 rejected program left data", v, 32'hFFFFFFFF);
    rreg(44, v); chk("R12 busy error cleared", v, 0);
    idle(2);
    report();
    $finish;
  end
endmodule